// File: doc/BRIEF.md
# Sideband MSR Read Command Handler

This block serves one read-only management command that arrives already deframed from a sideband bus. The command reads a 64-bit model-specific register of one logical thread in a multi-thread processor. The request arrives as a byte stream. Its first byte is flagged as start of frame and its last as end of frame, and the write and read length fields of the frame are held on side inputs. The block checks the frame and decides whether the target thread may be served. For a good frame it fetches the qword over a request/acknowledge port. It then emits a response byte stream that always begins with a completion code.

The write bytes are, in order: opcode, host/retry byte, processor ID, MSR address low byte and MSR address high byte. A malformed frame never reaches the MSR port. Neither does a frame that targets an absent thread. A fetch that is not acknowledged within a parameterised number of cycles is answered with a timeout code, so a stuck register agent cannot hang the management path.

Top module: `msr_rd_handler`

## Requirements
- R1: After reset `rsp_valid_o` and `msr_req_o` are 0.
- R2: A frame is well formed only if `req_wr_len_i` is 5, `req_rd_len_i` is 9, exactly 5 bytes lie between start and end of frame, and byte 0 is 0xB1. Byte 2 is the processor ID and bytes 3 and 4 are the MSR address low and high bytes.
- R3: A successful read gives 9 response bytes on consecutive cycles: 0x40 first, then the 64-bit data least significant byte first, with `rsp_last_o` set only on the ninth byte.
- R4: A well-formed-length frame whose opcode is not 0xB1 gives a single response byte 0x80 with `rsp_last_o` set, and `msr_req_o` stays 0.
- R5: A frame with a write length other than 5, a read length other than 9 or a received byte count other than 5 gives a single response byte 0x80, and `msr_req_o` stays 0.
- R6: A well-formed frame whose processor ID is NUM_THREADS or more, or whose bit in `thread_avail_i` is 0, gives a single response byte 0x90, and `msr_req_o` stays 0.
- R7: During a fetch, `msr_req_o` stays high with `msr_thread_o` and `msr_addr_o` equal to the request's processor ID and address until `msr_ack_i` is sampled high. It drops in the following cycle. No response byte is emitted while it is high.
- R8: If `msr_ack_i` is not sampled high during the first TIMEOUT_CYC cycles of `msr_req_o`, the response is the single byte 0x81. An acknowledge in the last of those cycles still gives a successful read.
- R9: `host_id_o` shows byte 1 of the most recent frame, and the response does not depend on that byte.
- R10: A frame that fails the opcode or length check is answered 0x80 even when its processor ID is unavailable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request byte valid |
| req_sof_i | input | 1 | First byte of frame |
| req_eof_i | input | 1 | Last byte of frame |
| req_byte_i | input | 8 | Request byte |
| req_wr_len_i | input | 8 | Frame write length, held for the frame |
| req_rd_len_i | input | 8 | Frame read length, held for the frame |
| thread_avail_i | input | NUM_THREADS | One bit per logical thread, 1 = available |
| msr_req_o | output | 1 | MSR fetch request |
| msr_thread_o | output | $clog2(NUM_THREADS) | Thread being read |
| msr_addr_o | output | 16 | MSR address being read |
| msr_ack_i | input | 1 | Fetch acknowledge, data valid |
| msr_data_i | input | 64 | Fetched MSR data |
| rsp_valid_o | output | 1 | Response byte valid |
| rsp_byte_o | output | 8 | Response byte |
| rsp_last_o | output | 1 | Last response byte |
| host_id_o | output | 8 | Host/retry byte of latest frame |

## Verification
The assertions take three things for granted. `thread_avail_i` stays stable while a fetch is outstanding. A new frame only arrives once the previous response has ended. `msr_ack_i` is raised only while `msr_req_o` is high. The bench keeps to all three: it changes the availability vector only between transactions and waits for `rsp_last_o` before sending the next frame. Its register model asserts the acknowledge a programmed number of cycles after it sees the request and clears it one cycle later.

// File: rtl/msr_rd_pkg.sv
package msr_rd_pkg;
  localparam logic [7:0] OPC_RD_MSR = 8'hB1;
  localparam logic [7:0] WR_LEN     = 8'd5;
  localparam logic [7:0] RD_LEN     = 8'd9;
  localparam int         QW_BYTES   = 8;

  localparam logic [7:0] CC_OK      = 8'h40;
  localparam logic [7:0] CC_BAD     = 8'h80;
  localparam logic [7:0] CC_TMO     = 8'h81;
  localparam logic [7:0] CC_NO_THR  = 8'h90;

  typedef struct packed {
    logic        bad;
    logic [7:0]  thread;
    logic [15:0] addr;
  } msr_cmd_t;
endpackage

// File: rtl/msr_req_parser.sv
module msr_req_parser
  import msr_rd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       sof_i,
  input  logic       eof_i,
  input  logic [7:0] byte_i,
  input  logic [7:0] wr_len_i,
  input  logic [7:0] rd_len_i,
  output logic       cmd_valid_o,
  output msr_cmd_t   cmd_o,
  output logic [7:0] host_o
);
  localparam int NFLD = 5;

  logic [7:0] fld_q [NFLD];
  logic [2:0] cnt_q;
  logic [2:0] pos;
  logic       len_ok_q;
  logic       done_q;

  assign pos = sof_i ? 3'd0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NFLD; i++) fld_q[i] <= '0;
      cnt_q    <= '0;
      len_ok_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= valid_i && eof_i;
      if (valid_i) begin
        if (int'(pos) < NFLD) fld_q[pos] <= byte_i;
        if (pos != 3'd7) cnt_q <= pos + 3'd1;
        if (sof_i) len_ok_q <= (wr_len_i == WR_LEN) && (rd_len_i == RD_LEN);
      end
    end
  end

  assign cmd_valid_o  = done_q;
  assign cmd_o.bad    = !len_ok_q || (cnt_q != 3'(NFLD)) || (fld_q[0] != OPC_RD_MSR);
  assign cmd_o.thread = fld_q[2];
  assign cmd_o.addr   = {fld_q[4], fld_q[3]};
  assign host_o       = fld_q[1];
endmodule

// File: rtl/msr_fetch_ctrl.sv
module msr_fetch_ctrl
  import msr_rd_pkg::*;
#(
  parameter int NUM_THREADS = 16,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cmd_valid_i,
  input  msr_cmd_t                       cmd_i,
  input  logic [NUM_THREADS-1:0]         thread_avail_i,
  output logic                           msr_req_o,
  output logic [$clog2(NUM_THREADS)-1:0] msr_thread_o,
  output logic [15:0]                    msr_addr_o,
  input  logic                           msr_ack_i,
  input  logic [8*QW_BYTES-1:0]          msr_data_i,
  input  logic                           rsp_done_i,
  output logic                           start_o,
  output logic [7:0]                     cc_o,
  output logic                           full_o,
  output logic [8*QW_BYTES-1:0]          data_o
);
  localparam int TID_W = $clog2(NUM_THREADS);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_SEND} state_e;
  state_e           state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             thr_ok;

  assign thr_ok = (int'(cmd_i.thread) < NUM_THREADS) &&
                  thread_avail_i[cmd_i.thread[TID_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      cnt_q        <= '0;
      msr_req_o    <= 1'b0;
      msr_thread_o <= '0;
      msr_addr_o   <= '0;
      start_o      <= 1'b0;
      cc_o         <= '0;
      full_o       <= 1'b0;
      data_o       <= '0;
    end else begin
      start_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (cmd_valid_i) begin
          if (cmd_i.bad) begin
            cc_o <= CC_BAD; full_o <= 1'b0; start_o <= 1'b1; state_q <= S_SEND;
          end else if (!thr_ok) begin
            cc_o <= CC_NO_THR; full_o <= 1'b0; start_o <= 1'b1; state_q <= S_SEND;
          end else begin
            msr_req_o    <= 1'b1;
            msr_thread_o <= cmd_i.thread[TID_W-1:0];
            msr_addr_o   <= cmd_i.addr;
            cnt_q        <= '0;
            state_q      <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (msr_ack_i) begin
            data_o <= msr_data_i; cc_o <= CC_OK; full_o <= 1'b1;
            msr_req_o <= 1'b0; start_o <= 1'b1; state_q <= S_SEND;
          end else if (cnt_q == CNT_W'(TIMEOUT_CYC - 1)) begin
            cc_o <= CC_TMO; full_o <= 1'b0;
            msr_req_o <= 1'b0; start_o <= 1'b1; state_q <= S_SEND;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_SEND: if (rsp_done_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msr_req_o && !msr_ack_i && cnt_q != CNT_W'(TIMEOUT_CYC - 1) |=> msr_req_o && $stable(msr_addr_o)); // R7
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msr_req_o && msr_ack_i |=> !msr_req_o); // R7
  AST_TMO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) < TIMEOUT_CYC); // R8
  AST_NO_REQ_ON_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_IDLE && cmd_valid_i && cmd_i.bad |=> !msr_req_o); // R4
endmodule

// File: rtl/msr_rsp_ser.sv
module msr_rsp_ser
  import msr_rd_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [7:0]            cc_i,
  input  logic                  full_i,
  input  logic [8*QW_BYTES-1:0] data_i,
  output logic                  rsp_valid_o,
  output logic [7:0]            rsp_byte_o,
  output logic                  rsp_last_o,
  output logic                  done_o
);
  localparam int NB    = QW_BYTES + 1;
  localparam int IDX_W = $clog2(NB);

  logic [7:0]       byte_a [NB];
  logic             active_q;
  logic [IDX_W-1:0] idx_q;

  assign byte_a[0] = cc_i;
  for (genvar g = 0; g < QW_BYTES; g++) begin : g_bytes
    assign byte_a[g+1] = data_i[8*g +: 8];
  end

  assign rsp_valid_o = active_q;
  assign rsp_byte_o  = byte_a[idx_q];
  assign rsp_last_o  = active_q && (full_i ? (idx_q == IDX_W'(QW_BYTES)) : (idx_q == '0));
  assign done_o      = rsp_last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (active_q) begin
      if (rsp_last_o) active_q <= 1'b0;
      else            idx_q    <= idx_q + 1'b1;
    end
  end

  AST_RSP_CONT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_last_o |=> rsp_valid_o); // R3
  AST_RSP_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_last_o |=> !rsp_valid_o); // R3
endmodule

// File: rtl/msr_rd_handler.sv
module msr_rd_handler
  import msr_rd_pkg::*;
#(
  parameter int NUM_THREADS = 16,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_valid_i,
  input  logic                           req_sof_i,
  input  logic                           req_eof_i,
  input  logic [7:0]                     req_byte_i,
  input  logic [7:0]                     req_wr_len_i,
  input  logic [7:0]                     req_rd_len_i,
  input  logic [NUM_THREADS-1:0]         thread_avail_i,
  output logic                           msr_req_o,
  output logic [$clog2(NUM_THREADS)-1:0] msr_thread_o,
  output logic [15:0]                    msr_addr_o,
  input  logic                           msr_ack_i,
  input  logic [63:0]                    msr_data_i,
  output logic                           rsp_valid_o,
  output logic [7:0]                     rsp_byte_o,
  output logic                           rsp_last_o,
  output logic [7:0]                     host_id_o
);
  msr_cmd_t              cmd;
  logic                  cmd_valid;
  logic                  start, full, done;
  logic [7:0]            cc;
  logic [8*QW_BYTES-1:0] data;

  msr_req_parser i_parser (
    .clk_i, .rst_ni,
    .valid_i(req_valid_i), .sof_i(req_sof_i), .eof_i(req_eof_i), .byte_i(req_byte_i),
    .wr_len_i(req_wr_len_i), .rd_len_i(req_rd_len_i),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .host_o(host_id_o)
  );

  msr_fetch_ctrl #(.NUM_THREADS(NUM_THREADS), .TIMEOUT_CYC(TIMEOUT_CYC)) i_fetch (
    .clk_i, .rst_ni,
    .cmd_valid_i(cmd_valid), .cmd_i(cmd), .thread_avail_i,
    .msr_req_o, .msr_thread_o, .msr_addr_o, .msr_ack_i, .msr_data_i,
    .rsp_done_i(done), .start_o(start), .cc_o(cc), .full_o(full), .data_o(data)
  );

  msr_rsp_ser i_ser (
    .clk_i, .rst_ni,
    .start_i(start), .cc_i(cc), .full_i(full), .data_i(data),
    .rsp_valid_o, .rsp_byte_o, .rsp_last_o, .done_o(done)
  );

  AST_REQ_AVAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msr_req_o |-> thread_avail_i[msr_thread_o]); // R6
  AST_QUIET_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msr_req_o |-> !rsp_valid_o); // R7
  AST_OK_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) && !rsp_last_o |-> rsp_byte_o == CC_OK); // R3
endmodule

// File: tb/test_msr_rd_handler.sv
module test_msr_rd_handler;
  localparam int NT = 16;
  localparam int TO = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_sof = 0, req_eof = 0;
  logic [7:0] req_byte = 0, wr_len = 0, rd_len = 0;
  logic [NT-1:0] avail = '1;
  logic msr_req, msr_ack = 0;
  logic [3:0] msr_thread;
  logic [15:0] msr_addr;
  logic [63:0] msr_data = 0;
  logic rsp_valid, rsp_last;
  logic [7:0] rsp_byte, host_id;

  always #4 clk = ~clk;

  msr_rd_handler #(.NUM_THREADS(NT), .TIMEOUT_CYC(TO)) i_msr_rd_handler (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_sof_i(req_sof), .req_eof_i(req_eof), .req_byte_i(req_byte),
    .req_wr_len_i(wr_len), .req_rd_len_i(rd_len), .thread_avail_i(avail),
    .msr_req_o(msr_req), .msr_thread_o(msr_thread), .msr_addr_o(msr_addr),
    .msr_ack_i(msr_ack), .msr_data_i(msr_data),
    .rsp_valid_o(rsp_valid), .rsp_byte_o(rsp_byte), .rsp_last_o(rsp_last), .host_id_o(host_id)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  int delay = 1, wait_n = 0;
  logic [7:0] rx [16];
  int rx_n = 0;
  bit done = 0, req_seen = 0, req_bad_field = 0;
  logic [3:0] exp_thr;
  logic [15:0] exp_addr;

  function automatic logic [63:0] mdata(logic [3:0] t, logic [15:0] a);
    return {a, ~a, 4'h0, t, 8'hA5 ^ {4'h0, t}, a ^ 16'h5A3C};
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
    if (rsp_valid) begin
      if (rx_n < 16) rx[rx_n] = rsp_byte;
      rx_n++;
      if (rsp_last) done = 1;
    end
    if (msr_ack) begin
      chk(!msr_req, "R7 req drop after ack", msr_req, 0);
      msr_ack = 0;
      wait_n = 0;
    end else if (msr_req) begin
      if (!req_seen) req_seen = 1;
      if (msr_thread != exp_thr || msr_addr != exp_addr) req_bad_field = 1;
      wait_n++;
      if (wait_n == delay) begin
        msr_ack = 1;
        msr_data = mdata(msr_thread, msr_addr);
      end
    end else wait_n = 0;
  end

  task automatic txn(logic [7:0] op, logic [7:0] host, logic [7:0] tid, logic [15:0] addr,
                     logic [7:0] wl, logic [7:0] rl, int nb, int dly, string tag);
    logic [7:0] b [7];
    logic [7:0] ecc;
    logic [7:0] exp [9];
    logic [63:0] d;
    int elen;
    bit fetch;
    b[0] = op; b[1] = host; b[2] = tid; b[3] = addr[7:0]; b[4] = addr[15:8];
    b[5] = 8'h11; b[6] = 8'h22;
    delay = dly; rx_n = 0; done = 0; req_seen = 0; req_bad_field = 0;
    exp_thr = tid[3:0]; exp_addr = addr;
    fetch = 0;
    if (wl != 5 || rl != 9 || nb != 5 || op != 8'hB1) ecc = 8'h80;
    else if (tid >= NT || !avail[tid[3:0]]) ecc = 8'h90;
    else begin
      fetch = 1;
      ecc = (dly > TO) ? 8'h81 : 8'h40;
    end
    elen = (ecc == 8'h40) ? 9 : 1;
    exp[0] = ecc;
    d = mdata(tid[3:0], addr);
    for (int i = 0; i < 8; i++) exp[i+1] = d[8*i +: 8];
    wr_len = wl; rd_len = rl;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      req_valid = 1; req_sof = (i == 0); req_eof = (i == nb - 1); req_byte = b[i];
    end
    @(negedge clk);
    req_valid = 0; req_sof = 0; req_eof = 0;
    for (int i = 0; i < 60 && !done; i++) begin
      @(negedge clk); #1;
    end
    begin
      bit ok = done && rx_n == elen;
      for (int i = 0; i < elen && i < rx_n; i++) if (rx[i] !== exp[i]) ok = 0;
      chk(ok, {tag, " response"}, {rx_n[7:0], rx[0]}, {elen[7:0], ecc});
    end
    chk(req_seen == fetch, {tag, " msr access"}, req_seen, fetch);
    if (fetch) chk(!req_bad_field, "R7 thread/addr held", req_bad_field, 0);
    chk(host_id == host, "R9 host byte", host_id, host);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0 && msr_req == 0, "R1 reset", {rsp_valid, msr_req}, 0);
    rst_n = 1;
    @(negedge clk);
    // R2 R3 R6: thread sweep
    avail = 16'hB6D3;
    for (int t = 0; t < NT; t++)
      txn(8'hB1, 8'(t * 3), 8'(t), 16'(t * 16'h1111 + 16'h0203), 5, 9, 5, 1 + (t % TO), "R3/R6 sweep");
    avail = '1;
    txn(8'hB1, 8'h01, 8'd16, 16'h1234, 5, 9, 5, 1, "R6 id 16");
    txn(8'hB1, 8'h01, 8'd200, 16'h1234, 5, 9, 5, 1, "R6 id 200");
    // R8: delay sweep across the limit
    for (int dl = 1; dl <= TO + 3; dl++)
      txn(8'hB1, 8'h05, 8'd7, 16'(16'hC000 + dl), 5, 9, 5, dl, "R8 delay");
    // R4: opcode sweep
    begin
      logic [7:0] ops [5] = '{8'h00, 8'hB0, 8'hB2, 8'hFF, 8'hA1};
      for (int i = 0; i < 5; i++) txn(ops[i], 8'h09, 8'd3, 16'h0010, 5, 9, 5, 1, "R4 opcode");
    end
    // R5: length sweeps
    for (int w = 0; w < 9; w++) txn(8'hB1, 8'h0A, 8'd2, 16'h0020, 8'(w), 9, 5, 1, "R5 wr len");
    begin
      logic [7:0] rls [5] = '{8'd0, 8'd1, 8'd8, 8'd10, 8'd255};
      for (int i = 0; i < 5; i++) txn(8'hB1, 8'h0B, 8'd2, 16'h0030, 5, rls[i], 5, 1, "R5 rd len");
    end
    txn(8'hB1, 8'h0C, 8'd2, 16'h0040, 5, 9, 4, 1, "R5 short");
    txn(8'hB1, 8'h0D, 8'd2, 16'h0040, 5, 9, 6, 1, "R5 long");
    // R10: malformed beats unavailable
    avail = 16'h0000;
    txn(8'hB2, 8'h0E, 8'd4, 16'h0050, 5, 9, 5, 1, "R10 opcode");
    txn(8'hB1, 8'h0E, 8'd4, 16'h0050, 6, 9, 5, 1, "R10 length");
    txn(8'hB1, 8'h0E, 8'd4, 16'h0050, 5, 9, 5, 1, "R6 none avail");
    avail = '1;
    // R9: host byte has no effect
    begin
      logic [7:0] hs [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
      for (int i = 0; i < 4; i++) txn(8'hB1, hs[i], 8'd9, 16'hBEEF, 5, 9, 5, 2, "R9 host");
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule